// File: doc/BRIEF.md
# PCI Interrupt Router

This block gathers level interrupt requests from a row of PCI slots, four pins per slot, and turns each change on a request into one routed event. A fixed table assigns each slot and pin an internal bridge interrupt number. Slot 5 keeps its four pins apart. Slots 6 and 7 each fold all four pins onto one number. The expansion slots 8 to 12 rotate their pins across a shared range. Requests from any other slot keep their raw pin number.

For each event, the number of the event is published on a side output. A single CPU interrupt line is then driven according to two configuration words, edge-select and polarity. Each word holds one bit for each internal index, where the index is the routed number minus the base. If the edge-select bit for the index is set, the CPU line gives a one-cycle pulse. If it is clear, the CPU line is set to the polarity bit for the index. Enable masking and status latching are done by other logic.

When several requests change in the same cycle, the block queues them. It services them one per clock, lowest line first.

Top module: `irq_router`

## Requirements
- R1: While `rst` is high, and on the first edge after it falls, `cpuIrq` is 0 and `irqNum` is 0. The request levels present during reset are taken as the starting state, so they raise no event.
- R2: A change on slot 5, pin p (request bit 20+p) is reported as number 32+p.
- R3: Any pin of slot 6 (bits 24..27) is reported as 36, and any pin of slot 7 (bits 28..31) is reported as 37.
- R4: Slot s in 8..12, pin p (bit 4s+p) is reported as 38+(s-8)+p, so the values run from 38 to 45.
- R5: Any other slot, pin p is reported as the number p. The CPU line then keeps its level. The one exception is a pulse still high from the previous cycle, which drops to 0.
- R6: If edge-select bit (number-32) is set, `cpuIrq` is 1 for exactly one cycle. It is 0 in the next cycle unless another event arrives in that cycle.
- R7: If that edge-select bit is clear, `cpuIrq` takes polarity bit (number-32). It holds that level until the next event.
- R8: An event is any change of a request bit, in either direction. Each event appears on the outputs at the clock edge after the change is presented, at most one event per edge, in ascending bit order (bit = 4·slot+pin). A bit that changes again while it is still waiting is serviced only once.
- R9: `irqNum` always holds the number of the most recently serviced event. It is unchanged on clocks that service no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irqReq | input | NUM_SLOTS*4 | Request levels; bit 4·slot+pin |
| edgeSel | input | CFG_BITS | Pulse-mode select, one bit per internal index |
| polarity | input | CFG_BITS | Level driven in non-pulse mode, one bit per internal index |
| irqNum | output | 8 | Number of the most recently serviced event |
| cpuIrq | output | 1 | Registered CPU interrupt line |

## Verification
The hardest state to reach is a queue of events that were pending together, crossing between slot classes. For example, a held level, then an untranslated slot, then a pulse arriving right behind another pulse. The bench flips several request bits in one cycle and leaves idle gaps of random length. The model reports a queued event under R8, separately from an event served at once. Directed steps fix up the fold-together slots, the last rotated pin, and a passthrough while the line is high.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

  localparam int PIN_COUNT  = 4;
  localparam int NUM_W      = 8;

  // Strobe from the control side: one serviced request line per clock.
  typedef struct packed {
    logic             valid;
    logic [NUM_W-1:0] lineIdx;
  } route_strobe_t;

  // Fixed slot/pin to bridge interrupt number table.
  function automatic logic [NUM_W-1:0] mapLine(input int slot, input int pin,
                                               input int base);
    int n;
    if (slot == 5)                    n = base + (pin % PIN_COUNT);
    else if (slot == 6)               n = base + 4;
    else if (slot == 7)               n = base + 5;
    else if (slot >= 8 && slot <= 12) n = base + 6 + (slot - 8) + pin;
    else                              n = pin;
    return NUM_W'(n);
  endfunction

endpackage

// File: rtl/irq_router_ctrl.sv
module irq_router_ctrl
  import irq_router_pkg::*;
#(
  parameter int NUM_LINES = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irqReq,
  output route_strobe_t        strobe
);

  logic [NUM_LINES-1:0] prevReq;
  logic [NUM_LINES-1:0] pending;
  logic [NUM_LINES-1:0] candidate;
  logic [NUM_LINES-1:0] grantMask;

  // New changes join the events still waiting from earlier cycles.
  always_comb candidate = pending | (irqReq ^ prevReq);

  // Lowest line wins: scan downward so the last hit is the smallest index.
  always_comb begin
    strobe    = '0;
    grantMask = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (candidate[i]) begin
        strobe.valid   = 1'b1;
        strobe.lineIdx = NUM_W'(i);
        grantMask      = '0;
        grantMask[i]   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevReq <= irqReq;
      pending <= '0;
    end else begin
      prevReq <= irqReq;
      pending <= candidate & ~grantMask;
    end
  end

endmodule

// File: rtl/irq_router_dp.sv
module irq_router_dp
  import irq_router_pkg::*;
#(
  parameter int IRQ_BASE = 32,
  parameter int CFG_BITS = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  route_strobe_t       strobe,
  input  logic [CFG_BITS-1:0] edgeSel,
  input  logic [CFG_BITS-1:0] polarity,
  output logic [NUM_W-1:0]    irqNum,
  output logic                cpuIrq
);

  localparam int IDX_W = (CFG_BITS > 1) ? $clog2(CFG_BITS) : 1;

  logic [NUM_W-1:0] mapped;
  logic [NUM_W-1:0] offset;
  logic [IDX_W-1:0] cfgIdx;
  logic             cfgHit;
  logic             pulseLive;

  always_comb begin
    mapped = mapLine(int'(strobe.lineIdx) / PIN_COUNT,
                     int'(strobe.lineIdx) % PIN_COUNT, IRQ_BASE);
    offset = mapped - NUM_W'(IRQ_BASE);
    cfgHit = (int'(mapped) >= IRQ_BASE) && (int'(offset) < CFG_BITS);
    cfgIdx = IDX_W'(offset);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irqNum    <= '0;
      cpuIrq    <= 1'b0;
      pulseLive <= 1'b0;
    end else if (strobe.valid && cfgHit) begin
      irqNum    <= mapped;
      cpuIrq    <= edgeSel[cfgIdx] ? 1'b1 : polarity[cfgIdx];
      pulseLive <= edgeSel[cfgIdx];
    end else begin
      if (strobe.valid) irqNum <= mapped;
      if (pulseLive) cpuIrq <= 1'b0;
      pulseLive <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_router.sv
module irq_router
  import irq_router_pkg::*;
#(
  parameter int NUM_SLOTS = 16,
  parameter int IRQ_BASE  = 32,
  parameter int CFG_BITS  = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [NUM_SLOTS*PIN_COUNT-1:0] irqReq,
  input  logic [CFG_BITS-1:0]          edgeSel,
  input  logic [CFG_BITS-1:0]          polarity,
  output logic [NUM_W-1:0]             irqNum,
  output logic                         cpuIrq
);

  localparam int NUM_LINES = NUM_SLOTS * PIN_COUNT;

  route_strobe_t strobe;

  irq_router_ctrl #(.NUM_LINES(NUM_LINES)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .irqReq (irqReq),
    .strobe (strobe)
  );

  irq_router_dp #(.IRQ_BASE(IRQ_BASE), .CFG_BITS(CFG_BITS)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .edgeSel  (edgeSel),
    .polarity (polarity),
    .irqNum   (irqNum),
    .cpuIrq   (cpuIrq)
  );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int IRQ_BASE = 32,
  parameter int CFG_BITS = 32
) (
  input logic                clk,
  input logic                rst,
  input logic                strobeValid,
  input logic [CFG_BITS-1:0] edgeSel,
  input logic [CFG_BITS-1:0] polarity,
  input logic [7:0]          irqNum,
  input logic                cpuIrq
);

  localparam int IDX_W = (CFG_BITS > 1) ? $clog2(CFG_BITS) : 1;

  logic                prevValid, prevCpu, prevPulse;
  logic [CFG_BITS-1:0] prevEdge, prevPol;
  logic [7:0]          prevIrq;
  logic [7:0]          offset;
  logic [IDX_W-1:0]    idx;
  logic                inRange, lastPulse;

  always_comb begin
    offset    = irqNum - 8'(IRQ_BASE);
    inRange   = (int'(irqNum) >= IRQ_BASE) && (int'(offset) < CFG_BITS);
    idx       = IDX_W'(offset);
    lastPulse = prevValid && inRange && prevEdge[idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prevValid <= 1'b0;
      prevCpu   <= 1'b0;
      prevPulse <= 1'b0;
      prevEdge  <= '0;
      prevPol   <= '0;
      prevIrq   <= '0;
    end else begin
      prevValid <= strobeValid;
      prevCpu   <= cpuIrq;
      prevPulse <= lastPulse;
      prevEdge  <= edgeSel;
      prevPol   <= polarity;
      prevIrq   <= irqNum;
    end
  end

  p_pulse_high_r6: assert property (@(posedge clk) disable iff (rst)
    (prevValid && inRange && prevEdge[idx]) |-> cpuIrq);

  p_pulse_drop_r6: assert property (@(posedge clk) disable iff (rst)
    (lastPulse && !strobeValid) |=> !cpuIrq);

  p_level_pol_r7: assert property (@(posedge clk) disable iff (rst)
    (prevValid && inRange && !prevEdge[idx]) |-> (cpuIrq == prevPol[idx]));

  p_level_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!prevValid && !prevPulse) |-> (cpuIrq == prevCpu));

  p_pass_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (prevValid && !inRange && !prevPulse) |-> (cpuIrq == prevCpu));

  p_num_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !prevValid |-> (irqNum == prevIrq));

endmodule

bind irq_router irq_router_chk #(.IRQ_BASE(IRQ_BASE), .CFG_BITS(CFG_BITS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .strobeValid (strobe.valid),
  .edgeSel     (edgeSel),
  .polarity    (polarity),
  .irqNum      (irqNum),
  .cpuIrq      (cpuIrq)
);

// File: tb/sim_irq_router.sv
module sim_irq_router;

  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] irqReq;
  logic [31:0] edgeSel, polarity;
  logic [7:0]  irqNum;
  logic        cpuIrq;

  always #5 clk = ~clk;

  irq_router u0 (
    .clk(clk), .rst(rst), .irqReq(irqReq), .edgeSel(edgeSel),
    .polarity(polarity), .irqNum(irqNum), .cpuIrq(cpuIrq)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [63:0] mPrev, mPend;
  logic        mCpu, mPulse;
  int          mNum;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int mapNum(input int s, input int p);
    if (s == 5) return 32 + p;
    if (s == 6) return 36;
    if (s == 7) return 37;
    if (s >= 8 && s <= 12) return 38 + (s - 8) + p;
    return p;
  endfunction

  function automatic string slotTag(input int s);
    if (s == 5) return "R2";
    if (s == 6 || s == 7) return "R3";
    if (s >= 8 && s <= 12) return "R4";
    return "R5";
  endfunction

  // Called at a negedge: drive, advance model one clock, compare at next negedge.
  task automatic step(input logic [63:0] nextReq);
    logic [63:0] cand;
    int found;
    string tagN, tagC;
    irqReq = nextReq;
    cand  = mPend | (nextReq ^ mPrev);
    mPrev = nextReq;
    found = -1;
    for (int i = 0; i < 64; i++) if (cand[i]) begin found = i; break; end
    if (found >= 0) begin
      tagN = mPend[found] ? "R8" : slotTag(found / 4);
      cand[found] = 1'b0;
      mNum = mapNum(found / 4, found % 4);
      if (mNum >= 32 && mNum < 64) begin
        if (edgeSel[mNum-32]) begin mCpu = 1'b1; mPulse = 1'b1; tagC = "R6"; end
        else begin mCpu = polarity[mNum-32]; mPulse = 1'b0; tagC = "R7"; end
      end else begin
        if (mPulse) mCpu = 1'b0;
        mPulse = 1'b0;
        tagC = "R5";
      end
    end else begin
      tagN = "R9";
      tagC = mPulse ? "R6" : "R7";
      if (mPulse) mCpu = 1'b0;
      mPulse = 1'b0;
    end
    mPend = cand;
    @(posedge clk);
    @(negedge clk);
    chk({tagN, " irqNum"}, int'(irqNum), mNum);
    chk({tagC, " cpuIrq"}, int'(cpuIrq), int'(mCpu));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; irqReq = '0; edgeSel = '0; polarity = '0;
    mPrev = '0; mPend = '0; mCpu = 1'b0; mPulse = 1'b0; mNum = 0;
    repeat (3) @(negedge clk);
    chk("R1 irqNum in reset", int'(irqNum), 0);
    chk("R1 cpuIrq in reset", int'(cpuIrq), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irqNum after reset", int'(irqNum), 0);
    chk("R1 cpuIrq after reset", int'(cpuIrq), 0);

    // R2 + R7: slot 5 pin 2 with polarity bit 2 set
    polarity = 32'h0000_0004;
    step(irqReq ^ (64'd1 << 22));
    // R4: slot 12 pin 3 -> 45, polarity bit 13 clear
    step(irqReq ^ (64'd1 << 51));
    // drive line high again via slot 5 pin 2 falling edge
    step(irqReq ^ (64'd1 << 22));
    // R5: slot 3 pin 1 passthrough keeps line high
    step(irqReq ^ (64'd1 << 13));
    // R8: slot 6 pin 2 and slot 9 pin 0 together
    step(irqReq ^ (64'd1 << 26) ^ (64'd1 << 36));
    step(irqReq);
    // R6: pulse on slot 7 (index 5)
    edgeSel = 32'h0000_0020;
    step(irqReq ^ (64'd1 << 28));
    step(irqReq);
    // R8: double toggle while waiting merges
    step(irqReq ^ (64'd1 << 20) ^ (64'd1 << 40));
    step(irqReq ^ (64'd1 << 40));
    step(irqReq);

    for (int n = 0; n < 400; n++) begin
      logic [63:0] nr;
      nr = irqReq;
      if ($urandom % 8 == 0) begin
        edgeSel  = $urandom & 32'h0000_3fff;
        polarity = $urandom;
      end
      if ($urandom % 3 != 0) begin
        for (int k = 0; k < int'($urandom % 3) + 1; k++)
          nr[8 + ($urandom % 48)] ^= 1'b1;
      end
      step(nr);
    end
    repeat (6) step(irqReq);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule